// File: doc/BRIEF.md
# Warp-Class-Aware L2 Replacement and Fill Controller

This block holds the recency state of one set-associative L2 bank and makes the replacement and fill decisions for it. On each request it receives a set index, the tag array's hit/miss verdict (with the hit way), and the divergence class of the warp that issued the request. A hit is always served from the cache, and the line becomes the most recently used line of its set. A miss from a warp that mostly or always misses can be sent straight to memory without allocating a line. Any other miss allocates a way, and the new line's place in the recency stack depends on the requester's class. Warps that tend to miss insert their lines at the least-recently-used end. Other warps insert at the most-recently-used end.

Recency is kept as true LRU order through a per-way age. Age 0 marks the most recently used way and age WAYS-1 the least recently used. The ages of a set always form a permutation. A line that a low-class warp brought in is promoted like any other line as soon as any warp hits on it, so lines with heavy reuse survive even though they were inserted at the LRU end. Data storage, tag matching, memory timing and the classification of warps belong to the neighbouring blocks.

Top module: `wcls_l2_repl`

## Requirements
- R1: After reset every way of every set is invalid, way w holds age w, and rsp_valid is 0. The first allocating miss to a set therefore takes way 0.
- R2: When bypass_en is 1, a miss whose class code is 3 or higher (3 mostly-miss, 4 all-miss, 5 to 7 treated as low) returns rsp_bypass=1 and rsp_fill=0, and changes neither the ages nor the valid bits.
- R3: When bypass_en is 0, a low-class miss allocates a way (rsp_fill=1, rsp_lru_ins=1) and leaves that way at age WAYS-1. The next allocating miss to the set evicts it again.
- R4: A miss with class code 0 (all-hit), 1 (mostly-hit) or 2 (balanced) never bypasses. It allocates a way with rsp_lru_ins=0 and leaves that way at age 0.
- R5: A hit answers rsp_bypass=0, rsp_fill=0 and rsp_way=req_way, and moves that way to age 0 for every class code, including low-class lines that are being reused.
- R6: The allocated way is the lowest-numbered invalid way of the set. If every way is valid, it is the way with age WAYS-1.
- R7: After every update the ages of the touched set are a permutation of 0..WAYS-1. Ways younger than an MRU-promoted way age by one. Ways older than an LRU-inserted way get one step younger.
- R8: The response appears exactly one clock after the request cycle. rsp_valid is 1 only in that cycle, and a request sees all state changes made by the request in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bypass_en | input | 1 | Allows low-class misses to skip the cache |
| req_valid | input | 1 | Request present this cycle |
| req_set | input | SET_W | Set index taken from the request address |
| req_hit | input | 1 | Tag array verdict: 1 means hit |
| req_way | input | WAY_W | Way that hit (meaningful only on a hit) |
| req_class | input | 3 | Divergence class of the requesting warp, codes as in R2/R4 |
| rsp_valid | output | 1 | Decision valid |
| rsp_bypass | output | 1 | Miss goes to memory without allocation |
| rsp_fill | output | 1 | Miss allocates rsp_way |
| rsp_lru_ins | output | 1 | Allocated line placed at the LRU end |
| rsp_way | output | WAY_W | Hit way or allocated way; 0 on bypass |

## Verification
A corrupted age vector or valid bit does not appear on the port of the request that caused it. It shows up at the next allocating miss to the same set, as a wrong rsp_way. When the set is full, that is often many requests later, after the bad age has moved toward the LRU end. The bench therefore follows every scenario with misses that drain the recency order. It also runs a long mixed sequence against an age model, so a wrong promotion, a wrong insertion point or a changed bypass decision shows up as a victim mismatch within a few requests to that set.

// File: rtl/wcls_pkg.sv
// Shared types and helpers for the warp-class-aware L2 replacement controller.
// Assumes class codes 0..2 are cache-friendly and all codes from 3 upward are low class.
package wcls_pkg;

    typedef enum logic [2:0] {
        WC_ALL_HIT     = 3'd0,
        WC_MOSTLY_HIT  = 3'd1,
        WC_BALANCED    = 3'd2,
        WC_MOSTLY_MISS = 3'd3,
        WC_ALL_MISS    = 3'd4
    } wclass_e;

    // True for classes whose lines are unlikely to be reused by their own warp.
    function automatic logic is_low_class(input logic [2:0] cls);
        return cls >= 3'(WC_MOSTLY_MISS);
    endfunction

endpackage

// File: rtl/wcls_policy.sv
// Class-driven policy: decides bypass, allocation and insertion end for one request.
// Assumes req_hit comes from a tag array that only reports hits on valid ways.
module wcls_policy
    import wcls_pkg::*;
(
    input  logic       hit,
    input  logic [2:0] cls,
    input  logic       bypass_en,
    output logic       bypass,
    output logic       fill,
    output logic       to_lru
);

    logic low;

    // Classify the request and derive the three decisions.
    always_comb begin
        low    = is_low_class(cls);
        bypass = !hit && low && bypass_en;
        fill   = !hit && !bypass;
        to_lru = low;
    end

endmodule

// File: rtl/wcls_victim.sv
// Victim selection for one set: lowest invalid way first, otherwise the oldest way.
// Assumes the ages form a permutation, so exactly one way holds the maximum age.
module wcls_victim #(
    parameter int WAYS  = 16,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            vld,
    input  logic [WAYS-1:0][WAY_W-1:0] age,
    output logic [WAY_W-1:0]           vic
);

    // Oldest way is the default; a lower invalid way overrides it.
    always_comb begin
        vic = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (age[i] == WAY_W'(WAYS - 1)) vic = WAY_W'(i);
        end
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!vld[i]) vic = WAY_W'(i);
        end
    end

endmodule

// File: rtl/wcls_age_update.sv
// Recency update for one set: moves a target way to the MRU end (age 0) or to the
// LRU end (age WAYS-1) and shifts the ways in between by one, preserving a permutation.
// Assumes the incoming ages are a permutation of 0..WAYS-1.
module wcls_age_update #(
    parameter int WAYS  = 16,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][WAY_W-1:0] age_in,
    input  logic [WAY_W-1:0]           tgt,
    input  logic                       to_lru,
    output logic [WAYS-1:0][WAY_W-1:0] age_out
);

    logic [WAY_W-1:0] tgt_age;

    // Age currently held by the target way.
    always_comb tgt_age = age_in[tgt];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        // Per-way new age for the selected insertion end.
        always_comb begin
            if (WAY_W'(w) == tgt) begin
                age_out[w] = to_lru ? WAY_W'(WAYS - 1) : '0;
            end else if (to_lru) begin
                age_out[w] = (age_in[w] > tgt_age) ? age_in[w] - 1'b1 : age_in[w];
            end else begin
                age_out[w] = (age_in[w] < tgt_age) ? age_in[w] + 1'b1 : age_in[w];
            end
        end
    end

endmodule

// File: rtl/wcls_l2_repl.sv
// Replacement and fill controller for one set-associative L2 bank. Holds per-set
// valid bits and true-LRU ages, and answers each request one cycle later with the
// bypass/fill decision, the insertion end and the way used.
// Assumes WAYS is a power of two, at most one request per cycle, and that hits
// are only reported on valid ways.
module wcls_l2_repl
    import wcls_pkg::*;
#(
    parameter int WAYS  = 16,
    parameter int SETS  = 16,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bypass_en,
    input  logic             req_valid,
    input  logic [SET_W-1:0] req_set,
    input  logic             req_hit,
    input  logic [WAY_W-1:0] req_way,
    input  logic [2:0]       req_class,
    output logic             rsp_valid,
    output logic             rsp_bypass,
    output logic             rsp_fill,
    output logic             rsp_lru_ins,
    output logic [WAY_W-1:0] rsp_way
);

    logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];
    logic [WAYS-1:0]            vld_q [SETS];

    logic [WAYS-1:0][WAY_W-1:0] cur_age, new_age;
    logic [WAYS-1:0]            cur_vld;
    logic                       bypass_c, fill_c, to_lru_c, upd_lru;
    logic [WAY_W-1:0]           vic_way, tgt_way;
    logic                       upd_en;
    logic [SET_W-1:0]           last_set_q;

    // Read the addressed set's state.
    always_comb begin
        cur_age = age_q[req_set];
        cur_vld = vld_q[req_set];
    end

    wcls_policy i_policy (
        .hit       (req_hit),
        .cls       (req_class),
        .bypass_en (bypass_en),
        .bypass    (bypass_c),
        .fill      (fill_c),
        .to_lru    (to_lru_c)
    );

    wcls_victim #(.WAYS(WAYS)) i_victim (
        .vld (cur_vld),
        .age (cur_age),
        .vic (vic_way)
    );

    // Pick the way to touch and whether the set's state changes.
    always_comb begin
        tgt_way = req_hit ? req_way : vic_way;
        upd_en  = req_valid && (req_hit || fill_c);
        upd_lru = !req_hit && to_lru_c;
    end

    wcls_age_update #(.WAYS(WAYS)) i_age_upd (
        .age_in  (cur_age),
        .tgt     (tgt_way),
        .to_lru  (upd_lru),
        .age_out (new_age)
    );

    // Recency and valid state: reset to ages 0..WAYS-1 and all invalid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
            end
        end else if (upd_en) begin
            age_q[req_set] <= new_age;
            if (fill_c) vld_q[req_set][tgt_way] <= 1'b1;
        end
    end

    // Register the decision one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_bypass  <= 1'b0;
            rsp_fill    <= 1'b0;
            rsp_lru_ins <= 1'b0;
            rsp_way     <= '0;
            last_set_q  <= '0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_bypass  <= req_valid && bypass_c;
            rsp_fill    <= req_valid && fill_c;
            rsp_lru_ins <= req_valid && fill_c && to_lru_c;
            rsp_way     <= (req_valid && !bypass_c) ? tgt_way : '0;
            last_set_q  <= req_set;
        end
    end

    // Checker view: which ages appear in the set touched last.
    logic [WAYS-1:0] seen;
    always_comb begin
        seen = '0;
        for (int w = 0; w < WAYS; w++) seen[age_q[last_set_q][w]] = 1'b1;
    end

    AST_AGE_PERM: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (&seen)); // R7

    AST_BYPASS_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_bypass |-> (!rsp_fill && !rsp_lru_ins)); // R2

    AST_LRU_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fill && rsp_lru_ins) |-> (age_q[last_set_q][rsp_way] == WAY_W'(WAYS - 1))); // R3

    AST_MRU_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fill && !rsp_lru_ins) |-> (age_q[last_set_q][rsp_way] == '0)); // R4

    AST_HIT_PROMOTE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_hit) |=> (age_q[last_set_q][rsp_way] == '0 && !rsp_fill && !rsp_bypass)); // R5

    AST_VICTIM_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && fill_c) |-> (!cur_vld[vic_way] || cur_age[vic_way] == WAY_W'(WAYS - 1))); // R6

    AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R8

    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R8

endmodule

// File: tb/test_wcls_l2_repl.sv
// Directed bench for wcls_l2_repl: one task per scenario, with an age/valid model
// built from the requirements.
module test_wcls_l2_repl;

    localparam int WAYS = 16;
    localparam int SETS = 16;
    localparam int WAY_W = $clog2(WAYS);
    localparam int SET_W = $clog2(SETS);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bypass_en = 1'b1;
    logic             req_valid = 1'b0;
    logic [SET_W-1:0] req_set = '0;
    logic             req_hit = 1'b0;
    logic [WAY_W-1:0] req_way = '0;
    logic [2:0]       req_class = '0;
    logic             rsp_valid, rsp_bypass, rsp_fill, rsp_lru_ins;
    logic [WAY_W-1:0] rsp_way;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    int mage [SETS][WAYS];
    bit mvld [SETS][WAYS];

    always #4 clk = ~clk;

    wcls_l2_repl #(.WAYS(WAYS), .SETS(SETS)) i_wcls_l2_repl (
        .clk, .rst_n, .bypass_en, .req_valid, .req_set, .req_hit, .req_way,
        .req_class, .rsp_valid, .rsp_bypass, .rsp_fill, .rsp_lru_ins, .rsp_way
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                mage[s][w] = w;
                mvld[s][w] = 0;
            end
    endtask

    task automatic model_move(input int s, input int t, input bit lru);
        int old;
        old = mage[s][t];
        for (int w = 0; w < WAYS; w++) begin
            if (w == t) mage[s][w] = lru ? WAYS - 1 : 0;
            else if (lru && mage[s][w] > old) mage[s][w]--;
            else if (!lru && mage[s][w] < old) mage[s][w]++;
        end
    endtask

    function automatic int model_victim(input int s);
        int v;
        v = 0;
        for (int w = 0; w < WAYS; w++) if (mage[s][w] == WAYS - 1) v = w;
        for (int w = WAYS - 1; w >= 0; w--) if (!mvld[s][w]) v = w;
        return v;
    endfunction

    // One request: drive, wait for the registered response, compare with the model.
    task automatic do_req(input int s, input bit hit, input int way, input int cls,
                          input string tag, output int got_way);
        bit low, exp_byp, exp_fill;
        int exp_way;
        low = (cls >= 3);
        exp_byp = !hit && low && bypass_en;
        exp_fill = !hit && !exp_byp;
        exp_way = hit ? way : (exp_byp ? 0 : model_victim(s));
        @(negedge clk);
        req_valid = 1'b1;
        req_set = SET_W'(s);
        req_hit = hit;
        req_way = WAY_W'(way);
        req_class = 3'(cls);
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R8 rsp_valid"}, int'(rsp_valid), 1);
        chk({tag, " bypass"}, int'(rsp_bypass), int'(exp_byp));
        chk({tag, " fill"}, int'(rsp_fill), int'(exp_fill));
        chk({tag, " lru_ins"}, int'(rsp_lru_ins), int'(exp_fill && low));
        chk({tag, " way"}, int'(rsp_way), exp_way);
        got_way = int'(rsp_way);
        if (hit) model_move(s, way, 1'b0);
        else if (exp_fill) begin
            mvld[s][exp_way] = 1;
            model_move(s, exp_way, low);
        end
    endtask

    task automatic t_reset();
        int g;
        chk("R1 rsp_valid in reset", int'(rsp_valid), 0);
        @(negedge clk);
        chk("R8 idle rsp_valid", int'(rsp_valid), 0);
        do_req(0, 0, 0, 0, "R1 first miss", g);
        chk("R1 first fill way", g, 0);
    endtask

    task automatic t_fill_order();
        int g;
        for (int i = 1; i < WAYS; i++) begin
            do_req(0, 0, 0, 1, "R4 fill", g);
            chk("R6 lowest invalid way", g, i);
        end
        do_req(0, 0, 0, 2, "R4 balanced miss", g);
        chk("R6 oldest way evicted", g, 0);
    endtask

    task automatic t_hit_promote();
        int g;
        do_req(0, 1, 1, 4, "R5 low-class hit", g);
        do_req(0, 0, 0, 0, "R5 after hit", g);
        chk("R5 promoted way spared", g, 2);
    endtask

    task automatic t_bypass();
        int g;
        bypass_en = 1'b1;
        do_req(0, 0, 0, 3, "R2 mostly-miss", g);
        do_req(0, 0, 0, 7, "R2 code 7", g);
        do_req(0, 0, 0, 0, "R2 state kept", g);
        chk("R2 victim unchanged", g, 3);
    endtask

    task automatic t_lru_insert();
        int g;
        bypass_en = 1'b0;
        do_req(0, 0, 0, 4, "R3 all-miss fill", g);
        chk("R3 lru victim", g, 4);
        do_req(0, 0, 0, 0, "R3 next miss", g);
        chk("R3 lru line evicted again", g, 4);
        bypass_en = 1'b1;
    endtask

    task automatic t_low_reuse();
        int g;
        for (int i = 0; i < WAYS; i++) do_req(1, 0, 0, 0, "R4 set1 fill", g);
        bypass_en = 1'b0;
        do_req(1, 0, 0, 3, "R3 set1 low fill", g);
        chk("R3 set1 low way", g, 0);
        do_req(1, 1, 0, 0, "R5 reuse hit", g);
        do_req(1, 0, 0, 1, "R5 reuse survives", g);
        chk("R5 reused line kept", g, 1);
        bypass_en = 1'b1;
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        req_valid = 1'b1; req_set = 2; req_hit = 1'b0; req_class = 0;
        @(negedge clk);
        req_set = 2; req_class = 0;
        chk("R8 b2b first way", int'(rsp_way), 0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 b2b second sees first", int'(rsp_way), 1);
        @(negedge clk);
        chk("R8 rsp_valid drops", int'(rsp_valid), 0);
        mvld[2][0] = 1; model_move(2, 0, 0);
        mvld[2][1] = 1; model_move(2, 1, 0);
    endtask

    task automatic t_mixed();
        int g;
        int r;
        r = 12345;
        for (int i = 0; i < 400; i++) begin
            int s, w, c;
            r = (r * 1103515245 + 12345) & 32'h7fffffff;
            s = (r >> 4) % 4;
            w = (r >> 9) % WAYS;
            c = (r >> 14) % 8;
            bypass_en = ((r >> 20) & 3) != 0;
            do_req(s, mvld[s][w] && ((r >> 18) & 1), w, c, "R7 mixed", g);
        end
        bypass_en = 1'b1;
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        t_reset_pre: chk("R1 rsp_valid low", int'(rsp_valid), 0);
        rst_n = 1'b1;
        t_reset();
        t_fill_order();
        t_hit_promote();
        t_bypass();
        t_lru_insert();
        t_low_reuse();
        t_back_to_back();
        t_mixed();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule